// File: doc/BRIEF.md
# Endian-Selectable Bus-Width Adapter

This block sits between a 36-bit long-word port and a narrower port. The narrow port can be set to carry 9-bit bytes, 18-bit half words, or the full 36 bits. In the unpacking direction it accepts one long word through a valid/ready handshake and sends it out as a series of bytes or half words. In the packing direction it collects bytes or half words and presents the finished long word. A long word holds four bytes or two half words. Narrow data always uses the low bits of a 36-bit bus, and the unused upper bits read as zero.

The byte order is taken from an input pin while reset is held, so the value present at the last clock of reset applies until the next reset. The same order applies to both directions. The narrow-port size is a static input that may change only while both directions are idle. Storage and clock-domain crossing belong to the surrounding logic.

Top module: `buswidth_adapter`

## Requirements
- R1: While `rst_n` is low, the order pin is sampled on every clock, and the value sampled at the last clock of reset is kept. High selects big-endian and low selects little-endian. Changes on the pin after reset is released have no effect.
- R2: Big-endian, byte size (`size_sel`=0), unpacking: the four bytes of a long word leave in the order [35:27], [26:18], [17:9], [8:0]. Each byte appears on `no_data[8:0]` with `no_data[35:9]` zero.
- R3: Little-endian, byte size, unpacking: the bytes leave in the order [8:0], [17:9], [26:18], [35:27].
- R4: Half size (`size_sel`=1), unpacking: two 18-bit pieces appear on `no_data[17:0]` with the upper bits zero. Big-endian sends [35:18] first and little-endian sends [17:0] first.
- R5: Big-endian packing: the first piece received (taken from the low bits of `ni_data`) becomes the most significant byte [35:27] in byte size, or the most significant half [35:18] in half size. The last piece received becomes the least significant part.
- R6: Little-endian packing: the first piece received becomes the least significant part ([8:0] for bytes, [17:0] for halves). The last piece received becomes the most significant part.
- R7: With `size_sel` set to 2 or 3 (full width), each long word passes through in a single transfer, unchanged, in both directions, whatever order was selected.
- R8: After `wi_ready` accepts a long word, it stays low until the last narrow piece of that word has been accepted downstream. It is high in the cycle after that acceptance.
- R9: While `no_valid` or `wo_valid` is high and its ready input is low, the valid signal stays high and its data is held stable.
- R10: `wo_valid` rises only after the last piece of a long word has been accepted. It falls in the cycle after `wo_ready` takes the word. A reset during assembly discards the partial long word.
- R11: During reset, `wi_ready` and `ni_ready` are 1, and `no_valid` and `wo_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| big_endian_pin | input | 1 | Order selection, sampled during reset (1 = big-endian) |
| size_sel | input | 2 | Narrow-port size: 0 = byte, 1 = half word, 2/3 = full width |
| wi_valid | input | 1 | Long word offered for unpacking |
| wi_ready | output | 1 | Unpacker can take a long word |
| wi_data | input | 36 | Long word to unpack |
| no_valid | output | 1 | Narrow piece available |
| no_ready | input | 1 | Downstream takes the narrow piece |
| no_data | output | 36 | Narrow piece, right-aligned |
| ni_valid | input | 1 | Narrow piece offered for packing |
| ni_ready | output | 1 | Packer can take a piece |
| ni_data | input | 36 | Narrow piece, right-aligned |
| wo_valid | output | 1 | Assembled long word available |
| wo_ready | input | 1 | Downstream takes the long word |
| wo_data | output | 36 | Assembled long word |

## Verification
The bench builds the adapter with its default lane width of 9 and four lanes. This reaches every size setting: four pieces, two pieces and one piece per long word. Running both byte orders under each size exposes lane placement mistakes that one setting alone could hide, such as swapped halves or a reversed byte index. The defaults also allow a reset to be applied after two of four bytes have arrived, so the bench can show that the partial long word is discarded.

// File: rtl/bwa_pkg.sv
package bwa_pkg;
    localparam int DEF_LANE_W = 9;
    localparam int DEF_LANES  = 4;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_FULL = 2'd2
    } size_e;
endpackage

// File: rtl/bwa_order_cap.sv
module bwa_order_cap (
    input  logic clk,
    input  logic rst_n,
    input  logic order_pin,
    output logic big_end
);
    typedef struct packed {
        logic big;
    } cap_state_t;

    cap_state_t cap_q, cap_d;

    always_comb begin
        cap_d = cap_q;
        if (!rst_n) begin
            cap_d.big = order_pin;
        end
    end

    always_ff @(posedge clk) begin
        cap_q <= cap_d;
    end

    assign big_end = cap_q.big;
endmodule

// File: rtl/bwa_lane_sel.sv
module bwa_lane_sel
    import bwa_pkg::*;
#(
    parameter int LANE_W = DEF_LANE_W,
    parameter int LANES  = DEF_LANES
) (
    input  logic [1:0]                              size_sel,
    input  logic                                    big_end,
    input  logic [((LANES > 1) ? $clog2(LANES) : 1)-1:0] idx,
    output logic [((LANES > 1) ? $clog2(LANES) : 1)-1:0] last_idx,
    output logic [LANE_W*LANES-1:0]                 mask,
    output logic [$clog2(LANE_W*LANES)+1-1:0]       sh
);
    localparam int WIDE_W = LANE_W * LANES;
    localparam int HALF_W = WIDE_W / 2;
    localparam int CNT_W  = (LANES > 1) ? $clog2(LANES) : 1;
    localparam int SH_W   = $clog2(WIDE_W) + 1;

    logic [CNT_W-1:0] lane_pos;

    always_comb begin
        case (size_sel)
            SZ_BYTE: begin
                last_idx = CNT_W'(LANES - 1);
                mask     = {{(WIDE_W - LANE_W){1'b0}}, {LANE_W{1'b1}}};
            end
            SZ_HALF: begin
                last_idx = CNT_W'(1);
                mask     = {{(WIDE_W - HALF_W){1'b0}}, {HALF_W{1'b1}}};
            end
            default: begin
                last_idx = '0;
                mask     = '1;
            end
        endcase

        lane_pos = big_end ? (last_idx - idx) : idx;

        case (size_sel)
            SZ_BYTE: sh = SH_W'(32'(lane_pos) * LANE_W);
            SZ_HALF: sh = SH_W'(32'(lane_pos) * HALF_W);
            default: sh = '0;
        endcase
    end
endmodule

// File: rtl/bwa_unpack.sv
module bwa_unpack
    import bwa_pkg::*;
#(
    parameter int LANE_W = DEF_LANE_W,
    parameter int LANES  = DEF_LANES
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     big_end,
    input  logic [1:0]               size_sel,
    input  logic                     in_valid,
    output logic                     in_ready,
    input  logic [LANE_W*LANES-1:0]  in_data,
    output logic                     out_valid,
    input  logic                     out_ready,
    output logic [LANE_W*LANES-1:0]  out_data
);
    localparam int WIDE_W = LANE_W * LANES;
    localparam int CNT_W  = (LANES > 1) ? $clog2(LANES) : 1;
    localparam int SH_W   = $clog2(WIDE_W) + 1;

    typedef struct packed {
        logic [WIDE_W-1:0] hold;
        logic [CNT_W-1:0]  idx;
        logic              busy;
    } unp_state_t;

    unp_state_t st_q, st_d;

    logic [CNT_W-1:0]  last_idx;
    logic [WIDE_W-1:0] mask;
    logic [SH_W-1:0]   sh;

    bwa_lane_sel #(.LANE_W(LANE_W), .LANES(LANES)) u_sel (
        .size_sel (size_sel),
        .big_end  (big_end),
        .idx      (st_q.idx),
        .last_idx (last_idx),
        .mask     (mask),
        .sh       (sh)
    );

    always_comb begin
        in_ready  = !st_q.busy;
        out_valid = st_q.busy;
        out_data  = (st_q.hold >> sh) & mask;

        st_d = st_q;
        if (in_valid && !st_q.busy) begin
            st_d.hold = in_data;
            st_d.idx  = '0;
            st_d.busy = 1'b1;
        end else if (st_q.busy && out_ready) begin
            if (st_q.idx == last_idx) begin
                st_d.busy = 1'b0;
                st_d.idx  = '0;
            end else begin
                st_d.idx = st_q.idx + CNT_W'(1);
            end
        end
        if (!rst_n) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end
endmodule

// File: rtl/bwa_pack.sv
module bwa_pack
    import bwa_pkg::*;
#(
    parameter int LANE_W = DEF_LANE_W,
    parameter int LANES  = DEF_LANES
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     big_end,
    input  logic [1:0]               size_sel,
    input  logic                     in_valid,
    output logic                     in_ready,
    input  logic [LANE_W*LANES-1:0]  in_data,
    output logic                     out_valid,
    input  logic                     out_ready,
    output logic [LANE_W*LANES-1:0]  out_data
);
    localparam int WIDE_W = LANE_W * LANES;
    localparam int CNT_W  = (LANES > 1) ? $clog2(LANES) : 1;
    localparam int SH_W   = $clog2(WIDE_W) + 1;

    typedef struct packed {
        logic [WIDE_W-1:0] acc;
        logic [CNT_W-1:0]  idx;
        logic              done;
    } pk_state_t;

    pk_state_t st_q, st_d;

    logic [CNT_W-1:0]  last_idx;
    logic [WIDE_W-1:0] mask;
    logic [SH_W-1:0]   sh;
    logic [WIDE_W-1:0] placed;

    bwa_lane_sel #(.LANE_W(LANE_W), .LANES(LANES)) u_sel (
        .size_sel (size_sel),
        .big_end  (big_end),
        .idx      (st_q.idx),
        .last_idx (last_idx),
        .mask     (mask),
        .sh       (sh)
    );

    always_comb begin
        in_ready  = !st_q.done;
        out_valid = st_q.done;
        out_data  = st_q.acc;
        placed    = (in_data & mask) << sh;

        st_d = st_q;
        if (in_valid && !st_q.done) begin
            st_d.acc = st_q.acc | placed;
            if (st_q.idx == last_idx) begin
                st_d.done = 1'b1;
                st_d.idx  = '0;
            end else begin
                st_d.idx = st_q.idx + CNT_W'(1);
            end
        end else if (st_q.done && out_ready) begin
            st_d.done = 1'b0;
            st_d.acc  = '0;
        end
        if (!rst_n) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end
endmodule

// File: rtl/buswidth_adapter.sv
module buswidth_adapter
    import bwa_pkg::*;
#(
    parameter int LANE_W = DEF_LANE_W,
    parameter int LANES  = DEF_LANES
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    big_endian_pin,
    input  logic [1:0]              size_sel,
    input  logic                    wi_valid,
    output logic                    wi_ready,
    input  logic [LANE_W*LANES-1:0] wi_data,
    output logic                    no_valid,
    input  logic                    no_ready,
    output logic [LANE_W*LANES-1:0] no_data,
    input  logic                    ni_valid,
    output logic                    ni_ready,
    input  logic [LANE_W*LANES-1:0] ni_data,
    output logic                    wo_valid,
    input  logic                    wo_ready,
    output logic [LANE_W*LANES-1:0] wo_data
);
    logic big_end;

    bwa_order_cap u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .order_pin (big_endian_pin),
        .big_end   (big_end)
    );

    bwa_unpack #(.LANE_W(LANE_W), .LANES(LANES)) u_unpack (
        .clk       (clk),
        .rst_n     (rst_n),
        .big_end   (big_end),
        .size_sel  (size_sel),
        .in_valid  (wi_valid),
        .in_ready  (wi_ready),
        .in_data   (wi_data),
        .out_valid (no_valid),
        .out_ready (no_ready),
        .out_data  (no_data)
    );

    bwa_pack #(.LANE_W(LANE_W), .LANES(LANES)) u_pack (
        .clk       (clk),
        .rst_n     (rst_n),
        .big_end   (big_end),
        .size_sel  (size_sel),
        .in_valid  (ni_valid),
        .in_ready  (ni_ready),
        .in_data   (ni_data),
        .out_valid (wo_valid),
        .out_ready (wo_ready),
        .out_data  (wo_data)
    );
endmodule

// File: rtl/bwa_chk.sv
module bwa_chk #(
    parameter int WIDE_W = 36
) (
    input logic              clk,
    input logic              rst_n,
    input logic              big_end,
    input logic [1:0]        size_sel,
    input logic              wi_valid,
    input logic              wi_ready,
    input logic [WIDE_W-1:0] wi_data,
    input logic              no_valid,
    input logic              no_ready,
    input logic [WIDE_W-1:0] no_data,
    input logic              ni_valid,
    input logic              ni_ready,
    input logic [WIDE_W-1:0] ni_data,
    input logic              wo_valid,
    input logic              wo_ready,
    input logic [WIDE_W-1:0] wo_data
);
    // R1
    order_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(big_end));

    // R8
    take_then_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wi_valid && wi_ready) |=> (no_valid && !wi_ready));

    // R9
    narrow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (no_valid && !no_ready) |=> (no_valid && $stable(no_data)));

    // R9
    wide_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wo_valid && !wo_ready) |=> (wo_valid && $stable(wo_data)));

    // R7
    full_unpack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (size_sel[1] && wi_valid && wi_ready) |=> (no_data == $past(wi_data)));

    // R7
    full_pack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (size_sel[1] && ni_valid && ni_ready) |=> (wo_valid && wo_data == $past(ni_data)));

    // R10
    wide_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wo_valid && wo_ready) |=> !wo_valid);

    // R11
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (wi_ready && ni_ready && !no_valid && !wo_valid));
endmodule

bind buswidth_adapter bwa_chk #(.WIDE_W(LANE_W*LANES)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .big_end  (big_end),
    .size_sel (size_sel),
    .wi_valid (wi_valid),
    .wi_ready (wi_ready),
    .wi_data  (wi_data),
    .no_valid (no_valid),
    .no_ready (no_ready),
    .no_data  (no_data),
    .ni_valid (ni_valid),
    .ni_ready (ni_ready),
    .ni_data  (ni_data),
    .wo_valid (wo_valid),
    .wo_ready (wo_ready),
    .wo_data  (wo_data)
);

// File: tb/buswidth_adapter_tb.sv
`timescale 1ns/1ps
module buswidth_adapter_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        big_endian_pin = 1'b0;
    logic [1:0]  size_sel = 2'd0;
    logic        wi_valid = 1'b0;
    logic        wi_ready;
    logic [35:0] wi_data = '0;
    logic        no_valid;
    logic        no_ready = 1'b0;
    logic [35:0] no_data;
    logic        ni_valid = 1'b0;
    logic        ni_ready;
    logic [35:0] ni_data = '0;
    logic        wo_valid;
    logic        wo_ready = 1'b0;
    logic [35:0] wo_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    buswidth_adapter u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .big_endian_pin (big_endian_pin),
        .size_sel       (size_sel),
        .wi_valid       (wi_valid),
        .wi_ready       (wi_ready),
        .wi_data        (wi_data),
        .no_valid       (no_valid),
        .no_ready       (no_ready),
        .no_data        (no_data),
        .ni_valid       (ni_valid),
        .ni_ready       (ni_ready),
        .ni_data        (ni_data),
        .wo_valid       (wo_valid),
        .wo_ready       (wo_ready),
        .wo_data        (wo_data)
    );

    task automatic check(input string req, input logic [35:0] act, input logic [35:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int pieces(input logic [1:0] sz);
        return (sz == 2'd0) ? 4 : (sz == 2'd1) ? 2 : 1;
    endfunction

    // k-th piece in transfer order, per R2..R7
    function automatic logic [35:0] exp_piece(input logic [35:0] w, input logic [1:0] sz,
                                              input bit big, input int k);
        int n, pw, lane;
        logic [63:0] m;
        n    = pieces(sz);
        pw   = 36 / n;
        lane = big ? (n - 1 - k) : k;
        m    = (64'd1 << pw) - 64'd1;
        return 36'((64'(w) >> (lane * pw)) & m);
    endfunction

    task automatic send_wide(input logic [35:0] d);
        @(negedge clk);
        wi_valid = 1'b1;
        wi_data  = d;
        while (!wi_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        wi_valid = 1'b0;
    endtask

    task automatic recv_narrow(output logic [35:0] d);
        no_ready = 1'b1;
        while (!no_valid) @(negedge clk);
        d = no_data;
        @(posedge clk);
        @(negedge clk);
        no_ready = 1'b0;
    endtask

    task automatic send_narrow(input logic [35:0] d);
        @(negedge clk);
        ni_valid = 1'b1;
        ni_data  = d;
        while (!ni_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        ni_valid = 1'b0;
    endtask

    task automatic recv_wide(output logic [35:0] d);
        wo_ready = 1'b1;
        while (!wo_valid) @(negedge clk);
        d = wo_data;
        @(posedge clk);
        @(negedge clk);
        wo_ready = 1'b0;
    endtask

    // R1, R11: reset with a chosen order, then move the pin away
    task automatic t_reset(input bit big);
        @(negedge clk);
        rst_n = 1'b0;
        big_endian_pin = big;
        repeat (3) @(negedge clk);
        check("R11 wi_ready in reset", 36'(wi_ready), 36'd1);
        check("R11 ni_ready in reset", 36'(ni_ready), 36'd1);
        check("R11 no_valid in reset", 36'(no_valid), 36'd0);
        check("R11 wo_valid in reset", 36'(wo_valid), 36'd0);
        rst_n = 1'b1;
        @(negedge clk);
        big_endian_pin = ~big;
    endtask

    task automatic t_unpack(input string req, input logic [35:0] w, input logic [1:0] sz, input bit big);
        logic [35:0] d;
        int n;
        n = pieces(sz);
        size_sel = sz;
        send_wide(w);
        for (int k = 0; k < n; k++) begin
            recv_narrow(d);
            check(req, d, exp_piece(w, sz, big, k));
            check("R8 wi_ready after piece", 36'(wi_ready), (k == n - 1) ? 36'd1 : 36'd0);
        end
    endtask

    task automatic t_pack(input string req, input logic [35:0] w, input logic [1:0] sz, input bit big);
        logic [35:0] d;
        int n;
        n = pieces(sz);
        size_sel = sz;
        for (int k = 0; k < n; k++) begin
            send_narrow(exp_piece(w, sz, big, k));
            check("R10 wo_valid after piece", 36'(wo_valid), (k == n - 1) ? 36'd1 : 36'd0);
        end
        recv_wide(d);
        check(req, d, w);
        check("R10 wo_valid after take", 36'(wo_valid), 36'd0);
    endtask

    task automatic t_stall(input logic [35:0] w, input bit big);
        logic [35:0] d;
        size_sel = 2'd0;
        send_wide(w);
        for (int c = 0; c < 3; c++) begin
            @(negedge clk);
            check("R9 no_valid held", 36'(no_valid), 36'd1);
            check("R9 no_data held", no_data, exp_piece(w, 2'd0, big, 0));
        end
        for (int k = 0; k < 4; k++) begin
            recv_narrow(d);
            check("R9 stalled order", d, exp_piece(w, 2'd0, big, k));
        end
        // packer side stall
        for (int k = 0; k < 4; k++) send_narrow(exp_piece(w, 2'd0, big, k));
        for (int c = 0; c < 3; c++) begin
            @(negedge clk);
            check("R9 wo_valid held", 36'(wo_valid), 36'd1);
            check("R9 wo_data held", wo_data, w);
        end
        recv_wide(d);
        check("R9 wide after stall", d, w);
    endtask

    task automatic t_midreset(input bit big);
        size_sel = 2'd0;
        send_narrow(36'h0_0000_01AB);
        send_narrow(36'h0_0000_00CD);
        t_reset(big);
        check("R10 partial discarded", 36'(wo_valid), 36'd0);
        t_pack("R10 fresh word after reset", 36'h9_8765_4321, 2'd0, big);
    endtask

    initial begin
        t_reset(1'b1);
        t_unpack("R1 order kept after pin change", 36'h1_2345_6789, 2'd0, 1'b1);
        t_unpack("R2 big byte unpack", 36'hF_EDCB_A987, 2'd0, 1'b1);
        t_unpack("R4 big half unpack", 36'hA_5A5A_1234, 2'd1, 1'b1);
        t_pack("R5 big byte pack", 36'h3_C0FF_EE12, 2'd0, 1'b1);
        t_pack("R5 big half pack", 36'h7_0F0F_8421, 2'd1, 1'b1);
        t_unpack("R7 full unpack big", 36'hC_AFEB_ABE5, 2'd2, 1'b1);
        t_pack("R7 full pack big", 36'h5_5AA5_0FF0, 2'd3, 1'b1);
        t_stall(36'hB_1234_5678, 1'b1);
        t_midreset(1'b1);

        t_reset(1'b0);
        t_unpack("R3 little byte unpack", 36'h1_2345_6789, 2'd0, 1'b0);
        t_unpack("R4 little half unpack", 36'hD_EADB_EEF1, 2'd1, 1'b0);
        t_pack("R6 little byte pack", 36'h8_7654_3210, 2'd0, 1'b0);
        t_pack("R6 little half pack", 36'h2_468A_CE13, 2'd1, 1'b0);
        t_unpack("R7 full unpack little", 36'hC_AFEB_ABE5, 2'd3, 1'b0);
        t_pack("R7 full pack little", 36'hE_0000_0001, 2'd2, 1'b0);
        t_midreset(1'b0);

        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule